// File: doc/BRIEF.md
# Hamming (7,4) Single-Error-Correcting Codec

This block pairs a four-bit-to-seven-bit Hamming encoder with a decoder that repairs any single flipped bit in a received seven-bit word. The encoder is purely combinational. It places three parity bits at the power-of-two positions 1, 2 and 4 of the word. The four message bits fill positions 3, 5, 6 and 7 in order.

The decoder recomputes the parity over the received word and forms a three-bit syndrome. Read as a binary number, the syndrome names the position of a lone bad bit. The syndrome is decoded into seven active-low position strobes plus an active-low clean flag. Each strobe inverts its own bit of the received word, which yields the corrected word and the corrected message.

Received words enter through a valid/ready stream and results leave through a second valid/ready stream. A word is taken when `rx_valid` and `rx_ready` are both high at a rising clock edge. A result is consumed when `dec_valid` and `dec_ready` are both high at a rising clock edge. With the default registered mode, the result sits in a single output stage. The rule for `rx_ready` is `!dec_valid || dec_ready`, so a stalled consumer stops the intake in the same cycle. With `REGISTERED` set to 0 the stage is a wire: `dec_valid` follows `rx_valid` and `rx_ready` follows `dec_ready`.

Top module: `hamming74_codec`

## Requirements
- R1: Bit i-1 of `msg_in` is message bit b_i, and bit p-1 of `code_out` is word position p. `code_out` holds, from position 1 to 7, the bits p1, p2, b1, p4, b2, b3, b4. These parity bits are p1 = b1^b2^b4, p2 = b1^b3^b4 and p4 = b2^b3^b4. For example, `msg_in` 4'b0101 gives `code_out` 7'b0101101.
- R2: `dec_syndrome` bit k is the XOR of every received position whose index has bit k set. For example, received 7'b0001101 (positions 1..7 = 1011000) gives syndrome 3'b110.
- R3: When a valid code word is received, `dec_syndrome` is 0 and `dec_ok_n` is low. All of `dec_pos_n` is high, `dec_word` equals the received word, and `dec_msg` holds positions 3, 5, 6 and 7.
- R4: When one bit at position p is flipped, `dec_syndrome` equals p and only `dec_pos_n[p-1]` is low. `dec_ok_n` is high, and `dec_word` and `dec_msg` equal the word and message that were sent.
- R5: When two bits at positions p and q are flipped, `dec_syndrome` equals p^q, which is nonzero. The block then flips position p^q, so `dec_word` differs from the word that was sent.
- R6: Exactly one line among `dec_ok_n` and the seven `dec_pos_n` lines is low at all times.
- R7: In registered mode, a result is valid in the cycle after its word is accepted.
- R8: While `dec_valid` is high and `dec_ready` is low, every result output holds its value and `rx_ready` is low.
- R9: After reset, `dec_valid` is low. The result outputs read as a clean decode of the all-zero word: syndrome 0, `dec_ok_n` low, `dec_pos_n` all high, and word and message 0.
- R10: A result that is consumed with no new word arriving drops `dec_valid` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_in | input | 4 | Message to encode, bit 0 = b1 |
| code_out | output | 7 | Encoded word, bit 0 = position 1 |
| rx_valid | input | 1 | Received word is offered |
| rx_ready | output | 1 | Decoder can take a word |
| rx_word | input | 7 | Received word, bit 0 = position 1 |
| dec_valid | output | 1 | Decode result is valid |
| dec_ready | input | 1 | Consumer takes the result |
| dec_word | output | 7 | Corrected word |
| dec_msg | output | 4 | Corrected message, bit 0 = b1 |
| dec_syndrome | output | 3 | Syndrome, the position of a single error |
| dec_pos_n | output | 7 | Active-low strobe per position, bit 0 = position 1 |
| dec_ok_n | output | 1 | Active-low: no error detected |

## Verification
A wrong parity mask or a wrong syndrome decode shows up as a wrong bit flip in `dec_word`. It also shows as a strobe on the wrong line, in the same cycle that the affected result becomes valid, one clock after its word is taken. A fault in the output stage's valid state shows at the handshake instead. A result can vanish while the consumer stalls, or it can linger after it has been consumed. Either case is visible within one cycle on `dec_valid` and `rx_ready`.

// File: rtl/ham_pkg.sv
package ham_pkg;
  localparam int CHK_BITS = 3;
  localparam int CW_BITS  = (1 << CHK_BITS) - 1;
  localparam int MSG_BITS = CW_BITS - CHK_BITS;

  typedef logic [CW_BITS-1:0]  cw_t;
  typedef logic [MSG_BITS-1:0] msg_t;
  typedef logic [CHK_BITS-1:0] syn_t;

  typedef struct packed {
    cw_t  word;
    msg_t msg;
    syn_t syn;
    cw_t  pos_n;
    logic ok_n;
  } dec_res_t;

  // True for positions that carry a parity bit (powers of two)
  function automatic bit is_chk_pos(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // Word position (1-based) that holds message bit j (0-based)
  function automatic int data_pos(input int j);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 1; p <= CW_BITS; p++) begin
      if (!is_chk_pos(p)) begin
        if (cnt == j) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  // Mask of positions whose binary index has bit k set
  function automatic cw_t cover_mask(input int k);
    cw_t m;
    m = '0;
    for (int p = 1; p <= CW_BITS; p++)
      m = m | (cw_t'((p >> k) & 1) << (p - 1));
    return m;
  endfunction
endpackage

// File: rtl/ham_encoder.sv
module ham_encoder
  import ham_pkg::*;
(
  input  msg_t msg,
  output cw_t  word
);
  cw_t data_only;

  generate
    for (genvar p = 1; p <= CW_BITS; p++) begin : g_chk_zero
      if (is_chk_pos(p)) begin : g_z
        assign data_only[p-1] = 1'b0;
      end
    end
    for (genvar j = 0; j < MSG_BITS; j++) begin : g_place
      assign data_only[data_pos(j)-1] = msg[j];
    end
    for (genvar p = 1; p <= CW_BITS; p++) begin : g_out
      if (is_chk_pos(p)) begin : g_par
        localparam int K = $clog2(p);
        assign word[p-1] = ^(data_only & cover_mask(K));
      end else begin : g_dat
        assign word[p-1] = data_only[p-1];
      end
    end
  endgenerate
endmodule

// File: rtl/ham_syndrome.sv
module ham_syndrome
  import ham_pkg::*;
(
  input  cw_t  rx,
  output syn_t syn
);
  generate
    for (genvar k = 0; k < CHK_BITS; k++) begin : g_syn
      assign syn[k] = ^(rx & cover_mask(k));
    end
  endgenerate
endmodule

// File: rtl/ham_corrector.sv
module ham_corrector
  import ham_pkg::*;
(
  input  cw_t      rx,
  input  syn_t     syn,
  output dec_res_t res
);
  cw_t pos_n;

  generate
    for (genvar p = 1; p <= CW_BITS; p++) begin : g_strobe
      assign pos_n[p-1] = (syn != syn_t'(p));
    end
  endgenerate

  cw_t fixed;
  assign fixed = rx ^ ~pos_n;

  msg_t msg;
  generate
    for (genvar j = 0; j < MSG_BITS; j++) begin : g_msg
      assign msg[j] = fixed[data_pos(j)-1];
    end
  endgenerate

  assign res.word  = fixed;
  assign res.msg   = msg;
  assign res.syn   = syn;
  assign res.pos_n = pos_n;
  assign res.ok_n  = (syn != '0);
endmodule

// File: rtl/ham_out_stage.sv
module ham_out_stage
  import ham_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     in_valid,
  output logic     in_ready,
  input  dec_res_t in_res,
  output logic     out_valid,
  input  logic     out_ready,
  output dec_res_t out_res
);
  localparam dec_res_t RES_IDLE = '{word: '0, msg: '0, syn: '0, pos_n: '1, ok_n: 1'b0};

  generate
    if (REGISTERED) begin : g_reg
      logic     vld_q;
      dec_res_t res_q;
      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_res   = res_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q <= 1'b0;
          res_q <= RES_IDLE;
        end else if (in_valid && in_ready) begin
          vld_q <= 1'b1;
          res_q <= in_res;
        end else if (out_ready) begin
          vld_q <= 1'b0;
        end
      end
    end else begin : g_wire
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_res   = in_res;
    end
  endgenerate
endmodule

// File: rtl/hamming74_codec.sv
module hamming74_codec
  import ham_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] msg_in,
  output logic [6:0] code_out,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [6:0] rx_word,
  output logic       dec_valid,
  input  logic       dec_ready,
  output logic [6:0] dec_word,
  output logic [3:0] dec_msg,
  output logic [2:0] dec_syndrome,
  output logic [6:0] dec_pos_n,
  output logic       dec_ok_n
);
  syn_t     syn;
  dec_res_t res_d;
  dec_res_t res_q;

  ham_encoder u_enc (.msg(msg_in), .word(code_out));
  ham_syndrome u_syn (.rx(rx_word), .syn(syn));
  ham_corrector u_cor (.rx(rx_word), .syn(syn), .res(res_d));

  ham_out_stage #(.REGISTERED(REGISTERED)) u_out (
    .clk(clk), .rst(rst),
    .in_valid(rx_valid), .in_ready(rx_ready), .in_res(res_d),
    .out_valid(dec_valid), .out_ready(dec_ready), .out_res(res_q)
  );

  assign dec_word     = res_q.word;
  assign dec_msg      = res_q.msg;
  assign dec_syndrome = res_q.syn;
  assign dec_pos_n    = res_q.pos_n;
  assign dec_ok_n     = res_q.ok_n;
endmodule

// File: rtl/ham_codec_chk.sv
module ham_codec_chk #(
  parameter bit REGISTERED = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       dec_valid,
  input logic       dec_ready,
  input logic [6:0] dec_word,
  input logic [2:0] dec_syndrome,
  input logic [6:0] dec_pos_n,
  input logic       dec_ok_n
);
  // R6: exactly one of the strobes and the clean flag is active
  p_one_line_r6: assert property (@(posedge clk) disable iff (rst)
    $countones({~dec_pos_n, ~dec_ok_n}) == 1);

  // R3 / R4: clean flag agrees with the syndrome
  p_clean_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (dec_syndrome == 3'd0) == !dec_ok_n);

  generate
    if (REGISTERED) begin : g_reg_props
      // R7: accepted word gives a valid result next cycle
      p_latency_r7: assert property (@(posedge clk) disable iff (rst)
        rx_valid && rx_ready |=> dec_valid);
      // R8: stalled result holds and intake stops
      p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        dec_valid && !dec_ready |=> dec_valid && $stable(dec_word) && $stable(dec_syndrome));
      p_stall_r8: assert property (@(posedge clk) disable iff (rst)
        dec_valid && !dec_ready |-> !rx_ready);
      // R10: consumed result with no new word clears valid
      p_drain_r10: assert property (@(posedge clk) disable iff (rst)
        dec_valid && dec_ready && !rx_valid |=> !dec_valid);
    end
  endgenerate
endmodule

bind hamming74_codec ham_codec_chk #(.REGISTERED(REGISTERED)) i_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_word(dec_word),
  .dec_syndrome(dec_syndrome), .dec_pos_n(dec_pos_n), .dec_ok_n(dec_ok_n)
);

// File: tb/test_hamming74_codec.sv
module test_hamming74_codec;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] msg_in = '0;
  logic [6:0] code_out;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [6:0] rx_word = '0;
  logic       dec_valid;
  logic       dec_ready = 1'b1;
  logic [6:0] dec_word;
  logic [3:0] dec_msg;
  logic [2:0] dec_syndrome;
  logic [6:0] dec_pos_n;
  logic       dec_ok_n;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hamming74_codec i_hamming74_codec (
    .clk(clk), .rst(rst), .msg_in(msg_in), .code_out(code_out),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_word(rx_word),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_word(dec_word),
    .dec_msg(dec_msg), .dec_syndrome(dec_syndrome), .dec_pos_n(dec_pos_n),
    .dec_ok_n(dec_ok_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference encoder from the R1 equations
  function automatic logic [6:0] ref_enc(input logic [3:0] m);
    logic b1, b2, b3, b4;
    b1 = m[0]; b2 = m[1]; b3 = m[2]; b4 = m[3];
    return {b4, b3, b2, b2^b3^b4, b1, b1^b3^b4, b1^b2^b4};
  endfunction

  // Reference syndrome from R2
  function automatic logic [2:0] ref_syn(input logic [6:0] w);
    return {w[3]^w[4]^w[5]^w[6], w[1]^w[2]^w[5]^w[6], w[0]^w[2]^w[4]^w[6]};
  endfunction

  // Offer one word and return at the negedge after acceptance
  task automatic send(input logic [6:0] w);
    @(negedge clk);
    rx_word  = w;
    rx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(dec_valid == 1'b0, "R9 valid", 32'(dec_valid), 0);
    check(dec_syndrome == 3'd0 && dec_ok_n == 1'b0, "R9 flags",
          {dec_syndrome, dec_ok_n}, 0);
    check(dec_pos_n == 7'h7f, "R9 strobes", 32'(dec_pos_n), 32'h7f);
    check(dec_word == 7'd0 && dec_msg == 4'd0, "R9 data", {dec_word, dec_msg}, 0);
  endtask

  task automatic t_encode;
    msg_in = 4'b0101;
    #1;
    check(code_out == 7'b0101101, "R1 example", 32'(code_out), 32'h2d);
    for (int m = 0; m < 16; m++) begin
      msg_in = 4'(m);
      #1;
      check(code_out == ref_enc(4'(m)), "R1 encode", 32'(code_out), 32'(ref_enc(4'(m))));
    end
  endtask

  task automatic t_example;
    send(7'b0001101);
    check(dec_syndrome == 3'b110, "R2 example syndrome", 32'(dec_syndrome), 32'h6);
    check(dec_word == 7'b0101101, "R4 example corrected", 32'(dec_word), 32'h2d);
    check(dec_pos_n == 7'b1011111, "R4 example strobe", 32'(dec_pos_n), 32'h5f);
  endtask

  task automatic t_clean;
    for (int m = 0; m < 16; m++) begin
      logic [6:0] cw;
      cw = ref_enc(4'(m));
      send(cw);
      check(dec_valid, "R7 valid", 32'(dec_valid), 1);
      check(dec_syndrome == 3'd0 && !dec_ok_n, "R3 flags", {dec_syndrome, dec_ok_n}, 0);
      check(dec_pos_n == 7'h7f, "R3 strobes", 32'(dec_pos_n), 32'h7f);
      check(dec_word == cw && dec_msg == 4'(m), "R3 data", {dec_word, dec_msg}, {cw, 4'(m)});
    end
  endtask

  task automatic t_single;
    for (int m = 0; m < 16; m++) begin
      for (int p = 1; p <= 7; p++) begin
        logic [6:0] cw, rx, strobe;
        cw = ref_enc(4'(m));
        rx = cw ^ (7'd1 << (p - 1));
        strobe = ~(7'd1 << (p - 1));
        send(rx);
        check(dec_syndrome == 3'(p) && ref_syn(rx) == 3'(p), "R2 syndrome",
              32'(dec_syndrome), 32'(p));
        check(dec_pos_n == strobe && dec_ok_n, "R4 strobe", {dec_pos_n, dec_ok_n}, {strobe, 1'b1});
        check(dec_word == cw && dec_msg == 4'(m), "R4 corrected", {dec_word, dec_msg}, {cw, 4'(m)});
      end
    end
  endtask

  task automatic t_double;
    for (int m = 0; m < 16; m += 3) begin
      for (int p = 1; p <= 7; p++) begin
        for (int q = p + 1; q <= 7; q++) begin
          logic [6:0] cw, rx, ew;
          logic [2:0] s;
          cw = ref_enc(4'(m));
          rx = cw ^ (7'd1 << (p - 1)) ^ (7'd1 << (q - 1));
          s  = 3'(p ^ q);
          ew = rx ^ (7'd1 << (s - 1));
          send(rx);
          check(dec_syndrome == s && s != 0, "R5 syndrome", 32'(dec_syndrome), 32'(s));
          check(dec_word == ew && dec_word != cw, "R5 miscorrection", 32'(dec_word), 32'(ew));
          check(dec_ok_n, "R5 flag", 32'(dec_ok_n), 1);
        end
      end
    end
  endtask

  task automatic t_backpressure;
    logic [6:0] w;
    w = ref_enc(4'hb) ^ 7'b0000100;
    @(negedge clk);
    dec_ready = 1'b0;
    send(w);
    for (int i = 0; i < 4; i++) begin
      check(dec_valid && !rx_ready, "R8 stall", {dec_valid, rx_ready}, 2'b10);
      check(dec_word == ref_enc(4'hb) && dec_syndrome == 3'd3, "R8 hold",
            {dec_word, dec_syndrome}, {ref_enc(4'hb), 3'd3});
      // offered word must not be taken while stalled
      rx_word = ref_enc(4'h2) ^ 7'b1000000;
      rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
    end
    check(dec_word == ref_enc(4'hb), "R8 not overwritten", 32'(dec_word), 32'(ref_enc(4'hb)));
    dec_ready = 1'b1;
    @(negedge clk);
    check(!dec_valid, "R10 drain", 32'(dec_valid), 0);
  endtask

  task automatic t_drain;
    send(ref_enc(4'h6));
    check(dec_valid, "R7 latency", 32'(dec_valid), 1);
    @(negedge clk);
    check(!dec_valid, "R10 drain", 32'(dec_valid), 0);
  endtask

  initial begin
    t_reset();
    t_encode();
    t_example();
    t_clean();
    t_single();
    t_double();
    t_backpressure();
    t_drain();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule